// File: doc/BRIEF.md
# Multicycle Instruction Sequencer Control

This block is the control state machine of a multicycle processor datapath in which a single memory serves both instructions and data and a single ALU does every addition, comparison and address calculation. It runs a small integer subset: register-to-register add, subtract, and, or and set-less-than, word load, word store, branch-if-equal and an absolute jump. Each instruction is spread over three to five clock cycles. The first two cycles are common to every instruction: fetch, then decode with register read. What comes after depends on the opcode class.

The machine is Moore-style. Every control line except the PC load strobe depends only on the current state. The PC load strobe also looks at the ALU zero flag, so that a branch updates the PC only when its two operands are equal. Decoding the function field into an ALU operation happens in a separate ALU control block. This machine only hands that block a 2-bit ALU mode. The opcode comes from the instruction register, which holds it steady from the end of fetch until the next fetch.

Top module: `seqctl_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state is fetch. This holds from any state, including mid-instruction.
- R2: Fetch drives the following, then moves to decode:
  - `mem_rd_en`=1, `mem_addr_data`=0, `ir_load`=1
  - `alu_a_reg`=0, `alu_b_sel`=1 (constant four), `alu_mode`=0 (add)
  - `pc_next_sel`=0 (live ALU result), `pc_upd`=1
- R3: Decode drives `alu_a_reg`=0, `alu_b_sel`=3 (immediate shifted left by two) and `alu_mode`=0. It asserts no write enable and no memory strobe.
- R4: Decode classifies the opcode as follows:
  - 0: register operation
  - 35: load
  - 43: store
  - 4: branch-if-equal
  - 2: jump
  - Any other value returns to fetch after decode, with no write enable, so the instruction takes 2 cycles.
- R5: A register operation executes with `alu_a_reg`=1, `alu_b_sel`=0 (register B) and `alu_mode`=2 (function field). It then writes back with `rf_wr_en`=1, `rf_dst_rd`=1 and `rf_data_mdr`=0, for 4 cycles in total.
- R6: A load runs in three steps after decode, for 5 cycles in total:
  - Address: `alu_a_reg`=1, `alu_b_sel`=2 (sign-extended immediate), `alu_mode`=0.
  - Memory read: `mem_rd_en`=1 with `mem_addr_data`=1.
  - Write-back: `rf_wr_en`=1, `rf_dst_rd`=0, `rf_data_mdr`=1.
- R7: A store runs the same address step as a load. It then asserts `mem_wr_en`=1 with `mem_addr_data`=1, for 4 cycles in total.
- R8: A branch drives `alu_a_reg`=1, `alu_b_sel`=0, `alu_mode`=1 (subtract), `pc_upd_if_eq`=1 and `pc_next_sel`=1 (ALU output register). `pc_load` follows `zero`, and the branch takes 3 cycles.
- R9: A jump drives `pc_upd`=1, `pc_next_sel`=2 (jump target) and `pc_load`=1, for 3 cycles in total.
- R10: Every control output not named for a state is 0. `pc_load` equals `pc_upd` OR (`pc_upd_if_eq` AND `zero`), so `zero` has no effect outside the branch state.
- R11: `mem_rd_en` and `mem_wr_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | OPC_W | Opcode field of the instruction register |
| zero | input | 1 | ALU zero flag |
| pc_upd | output | 1 | Unconditional PC write |
| pc_upd_if_eq | output | 1 | PC write qualified by zero |
| pc_load | output | 1 | Final PC load strobe |
| mem_addr_data | output | 1 | Memory address from ALU output register (1) or PC (0) |
| mem_rd_en | output | 1 | Memory read |
| mem_wr_en | output | 1 | Memory write |
| rf_data_mdr | output | 1 | Register write data from memory data register (1) or ALU output register (0) |
| ir_load | output | 1 | Instruction register load |
| pc_next_sel | output | 2 | PC source: 0 ALU, 1 ALU output register, 2 jump target |
| alu_mode | output | 2 | 0 add, 1 subtract, 2 function field |
| alu_a_reg | output | 1 | ALU A from register A (1) or PC (0) |
| alu_b_sel | output | 2 | 0 register B, 1 four, 2 immediate, 3 immediate shifted |
| rf_wr_en | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Destination from rd (1) or rt (0) |

## Verification
The assertions assume that `opcode` stays constant from the end of fetch until the next fetch, since it is meant to come from the instruction register. The load/store split is taken from the live opcode in the address state, so a change there would break the per-class sequences. The stimulus therefore holds each opcode for a whole instruction and changes it only at fetch boundaries. The one exception is a reset pulse, which abandons the instruction. `zero` is assumed to be meaningful only in the branch state. The bench toggles it in every other state to show that it has no effect there.

// File: rtl/seqctl_pkg.sv
`timescale 1ns/100ps
// Shared types and encodings for the multicycle sequencer control.
// Assumes a 6-bit opcode field unless the top overrides its width.
package seqctl_pkg;

    // Machine states. The order carries no meaning.
    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_MADDR, ST_MREAD, ST_LDWB,
        ST_MWRITE, ST_REXE, ST_RWB, ST_BRANCH, ST_JUMP
    } phase_t;

    // Instruction class produced by the opcode decoder.
    typedef enum logic [2:0] {
        CL_REG, CL_LOAD, CL_STORE, CL_BEQ, CL_JUMP, CL_NONE
    } iclass_t;

    // Opcode values.
    localparam int OPC_REG   = 0;
    localparam int OPC_LOAD  = 35;
    localparam int OPC_STORE = 43;
    localparam int OPC_BEQ   = 4;
    localparam int OPC_JUMP  = 2;

    // ALU B-input sources.
    localparam logic [1:0] BSRC_REG   = 2'd0;
    localparam logic [1:0] BSRC_FOUR  = 2'd1;
    localparam logic [1:0] BSRC_IMM   = 2'd2;
    localparam logic [1:0] BSRC_IMMSH = 2'd3;

    // PC sources.
    localparam logic [1:0] PSRC_ALU = 2'd0;
    localparam logic [1:0] PSRC_OUT = 2'd1;
    localparam logic [1:0] PSRC_JMP = 2'd2;

    // ALU modes.
    localparam logic [1:0] AMODE_ADD  = 2'd0;
    localparam logic [1:0] AMODE_SUB  = 2'd1;
    localparam logic [1:0] AMODE_FUNC = 2'd2;

    // Full set of state-driven control lines.
    typedef struct packed {
        logic       pc_upd;
        logic       pc_upd_if_eq;
        logic       mem_addr_data;
        logic       mem_rd_en;
        logic       mem_wr_en;
        logic       rf_data_mdr;
        logic       ir_load;
        logic [1:0] pc_next_sel;
        logic [1:0] alu_mode;
        logic       alu_a_reg;
        logic [1:0] alu_b_sel;
        logic       rf_wr_en;
        logic       rf_dst_rd;
    } ctl_t;

endpackage

// File: rtl/seqctl_opdec.sv
`timescale 1ns/100ps
// Maps the opcode field to an instruction class.
// Assumes the opcode is held steady by the instruction register.
module seqctl_opdec
    import seqctl_pkg::*;
#(
    parameter int OPC_W = 6
) (
    input  logic [OPC_W-1:0] opcode,
    output iclass_t          iclass
);

    // Compare against each known opcode; anything else is unsupported.
    always_comb begin
        iclass = CL_NONE;
        if (opcode == OPC_W'(OPC_REG))   iclass = CL_REG;
        if (opcode == OPC_W'(OPC_LOAD))  iclass = CL_LOAD;
        if (opcode == OPC_W'(OPC_STORE)) iclass = CL_STORE;
        if (opcode == OPC_W'(OPC_BEQ))   iclass = CL_BEQ;
        if (opcode == OPC_W'(OPC_JUMP))  iclass = CL_JUMP;
    end

endmodule

// File: rtl/seqctl_next.sv
`timescale 1ns/100ps
// Next-state logic of the sequencer.
// Every terminal state returns to fetch. Decode dispatches on the class.
// The address state splits load from store on the same class.
module seqctl_next
    import seqctl_pkg::*;
(
    input  phase_t  cur,
    input  iclass_t iclass,
    output phase_t  nxt
);

    // Choose the successor of the current state.
    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (iclass)
                    CL_REG:   nxt = ST_REXE;
                    CL_LOAD:  nxt = ST_MADDR;
                    CL_STORE: nxt = ST_MADDR;
                    CL_BEQ:   nxt = ST_BRANCH;
                    CL_JUMP:  nxt = ST_JUMP;
                    default:  nxt = ST_FETCH;
                endcase
            end
            ST_MADDR:  nxt = (iclass == CL_STORE) ? ST_MWRITE : ST_MREAD;
            ST_MREAD:  nxt = ST_LDWB;
            ST_REXE:   nxt = ST_RWB;
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/seqctl_outdec.sv
`timescale 1ns/100ps
// Moore output decoder: state to control lines.
// Each line starts inactive and each state raises only its own lines.
module seqctl_outdec
    import seqctl_pkg::*;
(
    input  phase_t cur,
    output ctl_t   ctl
);

    // Build the control word for the current state.
    always_comb begin
        ctl = '0;
        unique case (cur)
            ST_FETCH: begin
                ctl.mem_rd_en   = 1'b1;
                ctl.ir_load     = 1'b1;
                ctl.alu_b_sel   = BSRC_FOUR;
                ctl.alu_mode    = AMODE_ADD;
                ctl.pc_next_sel = PSRC_ALU;
                ctl.pc_upd      = 1'b1;
            end
            ST_DECODE: begin
                ctl.alu_b_sel = BSRC_IMMSH;
                ctl.alu_mode  = AMODE_ADD;
            end
            ST_MADDR: begin
                ctl.alu_a_reg = 1'b1;
                ctl.alu_b_sel = BSRC_IMM;
                ctl.alu_mode  = AMODE_ADD;
            end
            ST_MREAD: begin
                ctl.mem_rd_en     = 1'b1;
                ctl.mem_addr_data = 1'b1;
            end
            ST_LDWB: begin
                ctl.rf_wr_en    = 1'b1;
                ctl.rf_data_mdr = 1'b1;
            end
            ST_MWRITE: begin
                ctl.mem_wr_en     = 1'b1;
                ctl.mem_addr_data = 1'b1;
            end
            ST_REXE: begin
                ctl.alu_a_reg = 1'b1;
                ctl.alu_b_sel = BSRC_REG;
                ctl.alu_mode  = AMODE_FUNC;
            end
            ST_RWB: begin
                ctl.rf_wr_en  = 1'b1;
                ctl.rf_dst_rd = 1'b1;
            end
            ST_BRANCH: begin
                ctl.alu_a_reg    = 1'b1;
                ctl.alu_b_sel    = BSRC_REG;
                ctl.alu_mode     = AMODE_SUB;
                ctl.pc_upd_if_eq = 1'b1;
                ctl.pc_next_sel  = PSRC_OUT;
            end
            ST_JUMP: begin
                ctl.pc_upd      = 1'b1;
                ctl.pc_next_sel = PSRC_JMP;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/seqctl_top.sv
`timescale 1ns/100ps
// Control state machine of a multicycle shared-memory datapath.
// Holds the state register, decodes the opcode and produces the control lines.
// The PC strobe is qualified with the ALU zero flag.
// Assumes the opcode is stable between fetches.
module seqctl_top
    import seqctl_pkg::*;
#(
    parameter int OPC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             zero,
    output logic             pc_upd,
    output logic             pc_upd_if_eq,
    output logic             pc_load,
    output logic             mem_addr_data,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic             rf_data_mdr,
    output logic             ir_load,
    output logic [1:0]       pc_next_sel,
    output logic [1:0]       alu_mode,
    output logic             alu_a_reg,
    output logic [1:0]       alu_b_sel,
    output logic             rf_wr_en,
    output logic             rf_dst_rd
);

    phase_t  state_q;
    phase_t  state_d;
    iclass_t iclass;
    ctl_t    ctl;

    seqctl_opdec #(.OPC_W(OPC_W)) u_opdec (
        .opcode (opcode),
        .iclass (iclass)
    );

    seqctl_next u_next (
        .cur    (state_q),
        .iclass (iclass),
        .nxt    (state_d)
    );

    seqctl_outdec u_outdec (
        .cur (state_q),
        .ctl (ctl)
    );

    // State register with synchronous active-low reset into fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // Drive the ports from the control word and gate the PC strobe.
    always_comb begin
        pc_upd        = ctl.pc_upd;
        pc_upd_if_eq  = ctl.pc_upd_if_eq;
        mem_addr_data = ctl.mem_addr_data;
        mem_rd_en     = ctl.mem_rd_en;
        mem_wr_en     = ctl.mem_wr_en;
        rf_data_mdr   = ctl.rf_data_mdr;
        ir_load       = ctl.ir_load;
        pc_next_sel   = ctl.pc_next_sel;
        alu_mode      = ctl.alu_mode;
        alu_a_reg     = ctl.alu_a_reg;
        alu_b_sel     = ctl.alu_b_sel;
        rf_wr_en      = ctl.rf_wr_en;
        rf_dst_rd     = ctl.rf_dst_rd;
        pc_load       = ctl.pc_upd | (ctl.pc_upd_if_eq & zero);
    end

endmodule

// File: rtl/seqctl_chk.sv
`timescale 1ns/100ps
// Protocol checker for the sequencer control, attached by bind.
// Assumes the opcode is held between fetches.
module seqctl_chk #(
    parameter int OPC_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OPC_W-1:0] opcode,
    input logic             zero,
    input logic             pc_upd,
    input logic             pc_upd_if_eq,
    input logic             pc_load,
    input logic             mem_addr_data,
    input logic             mem_rd_en,
    input logic             mem_wr_en,
    input logic             rf_data_mdr,
    input logic             ir_load,
    input logic [1:0]       pc_next_sel,
    input logic [1:0]       alu_mode,
    input logic             alu_a_reg,
    input logic [1:0]       alu_b_sel,
    input logic             rf_wr_en,
    input logic             rf_dst_rd
);

    // R3
    fetch_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |=> (alu_b_sel == 2'd3 && !ir_load && !rf_wr_en && !mem_wr_en && !pc_upd));

    // R11
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R8
    branch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_upd_if_eq |-> (pc_next_sel == 2'd1 && alu_mode == 2'd1));

    // R5
    rf_write_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> ir_load);

    // R7
    store_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> ir_load);

    // R9
    jump_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_upd && pc_next_sel == 2'd2) |=> ir_load);

    // R10
    pc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_upd && !pc_upd_if_eq) |-> !pc_load);

    // R6
    load_data_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_data_mdr |-> (rf_wr_en && !rf_dst_rd && $past(mem_rd_en && mem_addr_data)));

endmodule

bind seqctl_top seqctl_chk #(.OPC_W(OPC_W)) u_chk (.*);

// File: tb/seqctl_top_test.sv
`timescale 1ns/100ps
// Self-checking bench with a behavioural phase model compared every clock.
module seqctl_top_test;

    localparam int P_FETCH = 0, P_DEC = 1, P_ADDR = 2, P_RD = 3, P_LWB = 4;
    localparam int P_WR = 5, P_EXE = 6, P_RWB = 7, P_BR = 8, P_JMP = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = '0;
    logic       zero = 1'b0;
    logic pc_upd, pc_upd_if_eq, pc_load, mem_addr_data, mem_rd_en, mem_wr_en;
    logic rf_data_mdr, ir_load, alu_a_reg, rf_wr_en, rf_dst_rd;
    logic [1:0] pc_next_sel, alu_mode, alu_b_sel;

    int checks = 0;
    int errors = 0;
    int ph = P_FETCH;
    int cyc = 0;
    bit armed = 1'b0;

    seqctl_top uut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .zero(zero),
        .pc_upd(pc_upd), .pc_upd_if_eq(pc_upd_if_eq), .pc_load(pc_load),
        .mem_addr_data(mem_addr_data), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .rf_data_mdr(rf_data_mdr), .ir_load(ir_load), .pc_next_sel(pc_next_sel),
        .alu_mode(alu_mode), .alu_a_reg(alu_a_reg), .alu_b_sel(alu_b_sel),
        .rf_wr_en(rf_wr_en), .rf_dst_rd(rf_dst_rd)
    );

    always #2 clk = ~clk;

    // Packed order: pc_upd, pc_upd_if_eq, addr_data, rd, wr, mdr, ir, pc_sel, mode, a, b, rfw, rd_dst, pc_load
    function automatic logic [16:0] want(input int p, input logic z);
        logic pu, pq, ad, rd, wr, md, ir, aa, rw, dd;
        logic [1:0] ps, am, bs;
        {pu, pq, ad, rd, wr, md, ir, aa, rw, dd} = '0;
        ps = 0; am = 0; bs = 0;
        if (p == P_FETCH) begin rd = 1; ir = 1; bs = 1; pu = 1; end
        if (p == P_DEC)   bs = 3;
        if (p == P_ADDR)  begin aa = 1; bs = 2; end
        if (p == P_RD)    begin rd = 1; ad = 1; end
        if (p == P_LWB)   begin rw = 1; md = 1; end
        if (p == P_WR)    begin wr = 1; ad = 1; end
        if (p == P_EXE)   begin aa = 1; am = 2; end
        if (p == P_RWB)   begin rw = 1; dd = 1; end
        if (p == P_BR)    begin aa = 1; am = 1; pq = 1; ps = 1; end
        if (p == P_JMP)   begin pu = 1; ps = 2; end
        return {pu, pq, ad, rd, wr, md, ir, ps, am, aa, bs, rw, dd, pu | (pq & z)};
    endfunction

    function automatic int succ(input int p, input logic [5:0] op);
        if (p == P_FETCH) return P_DEC;
        if (p == P_DEC) begin
            if (op == 0)  return P_EXE;
            if (op == 35 || op == 43) return P_ADDR;
            if (op == 4)  return P_BR;
            if (op == 2)  return P_JMP;
            return P_FETCH;
        end
        if (p == P_ADDR) return (op == 43) ? P_WR : P_RD;
        if (p == P_RD)   return P_LWB;
        if (p == P_EXE)  return P_RWB;
        return P_FETCH;
    endfunction

    function automatic string tag(input int p);
        if (p == P_FETCH) return "R2";
        if (p == P_DEC)   return "R3";
        if (p == P_ADDR || p == P_RD || p == P_LWB) return "R6";
        if (p == P_WR)    return "R7";
        if (p == P_EXE || p == P_RWB) return "R5";
        if (p == P_BR)    return "R8";
        return "R9";
    endfunction

    // One clock: drive at the falling edge, compare, then advance the model.
    task automatic step(input logic [5:0] op, input logic z, input logic rn);
        logic [16:0] e, a;
        @(negedge clk);
        opcode = op; zero = z; rst_n = rn;
        #1;
        if (armed) begin
            e = want(ph, z);
            a = {pc_upd, pc_upd_if_eq, mem_addr_data, mem_rd_en, mem_wr_en, rf_data_mdr,
                 ir_load, pc_next_sel, alu_mode, alu_a_reg, alu_b_sel, rf_wr_en, rf_dst_rd, pc_load};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s phase %0d actual %h expected %h", tag(ph), ph, a, e);
            end
            checks++; // R11
            if (mem_rd_en && mem_wr_en) begin
                errors++;
                $display("FAIL R11 actual rd=1 wr=1 expected not both");
            end
            if (ph != P_BR && z) begin
                checks++; // R10
                if (pc_load !== (ph == P_FETCH || ph == P_JMP)) begin
                    errors++;
                    $display("FAIL R10 phase %0d actual pc_load %b expected %b", ph, pc_load,
                             (ph == P_FETCH || ph == P_JMP));
                end
            end
        end
        cyc++;
        @(posedge clk);
        ph = rn ? succ(ph, op) : P_FETCH;
    endtask

    // Run one instruction from fetch back to fetch and check its length.
    task automatic run_instr(input logic [5:0] op, input logic zb, input int len, input string rq);
        int n;
        n = 0;
        do begin
            step(op, (ph == P_BR) ? zb : cyc[0], 1'b1);
            n++;
        end while (ph != P_FETCH && n < 8);
        checks++;
        if (n != len) begin
            errors++;
            $display("FAIL %s opcode %0d actual %0d cycles expected %0d", rq, op, n, len);
        end
    endtask

    // R1: fetch outputs appear in the cycle after a reset edge.
    task automatic check_r1();
        @(negedge clk);
        #1;
        checks++;
        if (!(ir_load === 1'b1 && pc_upd === 1'b1 && mem_rd_en === 1'b1 && rf_wr_en === 1'b0)) begin
            errors++;
            $display("FAIL R1 actual ir=%b pc=%b rd=%b rfw=%b expected 1 1 1 0",
                     ir_load, pc_upd, mem_rd_en, rf_wr_en);
        end
    endtask

    initial begin
        step(0, 0, 0);
        step(0, 0, 0);
        armed = 1'b1;
        check_r1();
        run_instr(0, 0, 4, "R5");
        run_instr(35, 0, 5, "R6");
        run_instr(43, 1, 4, "R7");
        run_instr(4, 1, 3, "R8");
        run_instr(4, 0, 3, "R8");
        run_instr(2, 0, 3, "R9");
        run_instr(7, 1, 2, "R4");
        run_instr(63, 0, 2, "R4");
        run_instr(34, 1, 2, "R4");
        run_instr(35, 1, 5, "R6");
        // R1: reset in the middle of a register operation.
        step(0, 0, 1);
        step(0, 0, 1);
        step(0, 0, 0);
        check_r1();
        run_instr(43, 0, 4, "R7");
        // R1: reset in the middle of a load.
        step(35, 0, 1);
        step(35, 0, 1);
        step(35, 0, 1);
        step(35, 0, 0);
        check_r1();
        run_instr(2, 1, 3, "R9");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule